// File: doc/BRIEF.md
# Bit-Test Execution Unit

This unit carries out the second opcode byte of a bit-test operation for an 8-bit processor core. The byte picks a bit position and an operand source. The source is one of seven 8-bit registers, or the byte in memory at the address held in the H/L register pair. The unit reads the operand and checks the chosen bit. It then produces an updated flag nibble together with a one-clock write strobe.

The core raises `start` in the first clock of the prefix-fetch machine cycle. The unit counts machine cycles from that clock, and each machine cycle lasts `CLKS_PER_MC` clocks (at least 3). A register operand finishes after two machine cycles. A memory operand finishes after three, because the extra machine cycle performs the memory read. The unit never writes the register file or memory. The carry flag passes through unchanged. A byte that does not belong to the bit-test group is reported as illegal and leaves the flags alone.

Top module: `bittest_unit`

## Requirements
- R1: The opcode byte is decoded as follows. Bits 7:6 equal to 01 mark a bit test, bits 5:3 give the bit index, and bits 2:0 give the operand code. The codes are 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory at {H,L}, 7=A. For register codes, `rd_sel` carries the operand code while the unit is busy.
- R2: In the done clock of a legal operation, `flags_out[3]` (zero) is 1 if the tested bit is 0, and 0 if it is 1.
- R3: In the done clock of a legal operation, `flags_out[2]` (subtract) is 0 and `flags_out[1]` (half-carry) is 1.
- R4: `flags_out[0]` (carry) equals the `flags_in[0]` value sampled with `start`.
- R5: For a register operand, `done` is high in clock 2*CLKS_PER_MC, counting the `start` clock as clock 1. It is high for that one clock only.
- R6: For a memory operand, `mem_rd` is high for exactly one clock, clock 2*CLKS_PER_MC+1, with `mem_addr` = {hl_h, hl_l}. The byte that returns in the next clock is tested, and `done` is high in clock 3*CLKS_PER_MC.
- R7: While the unit is busy, `start`, `opcode` and `flags_in` are ignored. The result and timing of the running operation do not change.
- R8: An opcode whose bits 7:6 are not 01 completes in 2 machine cycles with `illegal` and `done` high, `flags_we` low, and `flags_out` equal to the captured `flags_in`.
- R9: `flags_we` is high exactly in the done clock of a legal operation. `mem_rd` never rises for a register operand.
- R10: After reset, `busy`, `done`, `flags_we`, `illegal` and `mem_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Marks clock 1 of the prefix machine cycle |
| opcode | input | 8 | Second opcode byte, sampled with start |
| flags_in | input | 4 | Current flags {Z,N,H,C}, sampled with start |
| rd_sel | output | 3 | Register-file read select (operand code) |
| rd_data | input | 8 | Register-file read data for rd_sel |
| hl_h | input | 8 | H register (high address byte) |
| hl_l | input | 8 | L register (low address byte) |
| mem_addr | output | 16 | Memory read address |
| mem_rd | output | 1 | Memory read enable, data returned one clock later |
| mem_rdata | input | 8 | Memory read data |
| flags_out | output | 4 | Result flags {Z,N,H,C}, valid with done |
| flags_we | output | 1 | Flag write strobe |
| illegal | output | 1 | Opcode outside the bit-test group, valid with done |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final clock of the operation |

## Verification
The bench sweeps all 64 pairings of bit index and operand code with fresh random register and memory contents. This shows that each index reaches the right bit and each code reaches the right source, including the H/L-addressed memory path and its extra machine cycle. Data bytes of all zeros and all ones separate a stuck zero flag from a correct one. Both carry values are used to show the carry passes through. Operations with start held high and the opcode and flags changed while busy show that the captured operation is not disturbed. Illegal prefixes 00, 10 and 11 show the flags are held and the write strobe stays low.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int OPC_W  = 8;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;

    typedef enum logic [2:0] {
        SRC_B   = 3'd0,
        SRC_C   = 3'd1,
        SRC_D   = 3'd2,
        SRC_E   = 3'd3,
        SRC_H   = 3'd4,
        SRC_L   = 3'd5,
        SRC_MEM = 3'd6,
        SRC_A   = 3'd7
    } src_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    typedef struct packed {
        logic       legal;
        logic [2:0] bit_idx;
        src_e       src;
    } dec_t;

    function automatic dec_t decode_op(input logic [OPC_W-1:0] op);
        dec_t d;
        d.legal   = (op[7:6] == 2'b01);
        d.bit_idx = op[5:3];
        d.src     = src_e'(op[2:0]);
        return d;
    endfunction

    function automatic logic bit_is_clear(input logic [DATA_W-1:0] d,
                                          input logic [2:0] idx);
        return ~d[idx];
    endfunction

    function automatic logic uses_memory(input dec_t d);
        return d.legal && (d.src == SRC_MEM);
    endfunction

endpackage

// File: rtl/bt_seq.sv
module bt_seq #(
    parameter int CLKS_PER_MC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic mem_op,
    output logic accept,
    output logic busy,
    output logic done,
    output logic rf_cap,
    output logic mem_issue,
    output logic mem_cap
);
    localparam int CW = $clog2(3 * CLKS_PER_MC + 2) + 1;
    localparam logic [CW-1:0] T_REG  = CW'(2 * CLKS_PER_MC);
    localparam logic [CW-1:0] T_MEM  = CW'(3 * CLKS_PER_MC);
    localparam logic [CW-1:0] T_RF   = CW'(CLKS_PER_MC + 1);
    localparam logic [CW-1:0] T_ISS  = CW'(2 * CLKS_PER_MC + 1);
    localparam logic [CW-1:0] T_CAP  = CW'(2 * CLKS_PER_MC + 2);
    localparam logic [CW-1:0] T_SECOND = CW'(2);

    logic [CW-1:0] clk_idx;
    logic          run;
    logic [CW-1:0] last_idx;

    assign last_idx  = mem_op ? T_MEM : T_REG;
    assign accept    = start && !run;
    assign busy      = run;
    assign done      = run && (clk_idx == last_idx);
    assign rf_cap    = run && (clk_idx == T_RF);
    assign mem_issue = run && mem_op && (clk_idx == T_ISS);
    assign mem_cap   = run && mem_op && (clk_idx == T_CAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            clk_idx <= '0;
        end else if (accept) begin
            run     <= 1'b1;
            clk_idx <= T_SECOND;
        end else if (run) begin
            if (done) begin
                run     <= 1'b0;
                clk_idx <= '0;
            end else begin
                clk_idx <= clk_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bt_operand.sv
module bt_operand
    import bt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  dec_t              dec,
    input  logic              rf_cap,
    input  logic              mem_issue,
    input  logic              mem_cap,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] hl_h,
    input  logic [DATA_W-1:0] hl_l,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [2:0]        rd_sel,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic [DATA_W-1:0] operand
);
    assign rd_sel   = dec.src;
    assign mem_addr = {hl_h, hl_l};
    assign mem_rd   = mem_issue;

    always_ff @(posedge clk) begin
        if (rst) begin
            operand <= '0;
        end else if (mem_cap) begin
            operand <= mem_rdata;
        end else if (rf_cap && !uses_memory(dec)) begin
            operand <= rd_data;
        end
    end
endmodule

// File: rtl/bt_flags.sv
module bt_flags
    import bt_pkg::*;
(
    input  dec_t              dec,
    input  logic [DATA_W-1:0] operand,
    input  flags_t            saved,
    input  logic              done,
    output flags_t            result,
    output logic              we,
    output logic              illegal
);
    always_comb begin
        result = saved;
        if (dec.legal) begin
            result.z = bit_is_clear(operand, dec.bit_idx);
            result.n = 1'b0;
            result.h = 1'b1;
        end
    end

    assign we      = done && dec.legal;
    assign illegal = done && !dec.legal;
endmodule

// File: rtl/bittest_unit.sv
module bittest_unit
    import bt_pkg::*;
#(
    parameter int CLKS_PER_MC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [3:0]        flags_in,
    output logic [2:0]        rd_sel,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] hl_h,
    input  logic [DATA_W-1:0] hl_l,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [3:0]        flags_out,
    output logic              flags_we,
    output logic              illegal,
    output logic              busy,
    output logic              done
);
    logic [OPC_W-1:0]  op_q;
    flags_t            flags_q;
    dec_t              dec;
    logic              accept;
    logic              rf_cap;
    logic              mem_issue;
    logic              mem_cap;
    logic [DATA_W-1:0] operand;
    flags_t            result;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= '0;
            flags_q <= '0;
        end else if (accept) begin
            op_q    <= opcode;
            flags_q <= flags_t'(flags_in);
        end
    end

    assign dec = decode_op(op_q);

    bt_seq #(.CLKS_PER_MC(CLKS_PER_MC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mem_op    (uses_memory(dec)),
        .accept    (accept),
        .busy      (busy),
        .done      (done),
        .rf_cap    (rf_cap),
        .mem_issue (mem_issue),
        .mem_cap   (mem_cap)
    );

    bt_operand u_opnd (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .rf_cap    (rf_cap),
        .mem_issue (mem_issue),
        .mem_cap   (mem_cap),
        .rd_data   (rd_data),
        .hl_h      (hl_h),
        .hl_l      (hl_l),
        .mem_rdata (mem_rdata),
        .rd_sel    (rd_sel),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .operand   (operand)
    );

    bt_flags u_flags (
        .dec     (dec),
        .operand (operand),
        .saved   (flags_q),
        .done    (done),
        .result  (result),
        .we      (flags_we),
        .illegal (illegal)
    );

    assign flags_out = result;
endmodule

// File: rtl/bittest_unit_chk.sv
module bittest_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       mem_rd,
    input logic       flags_we,
    input logic       illegal,
    input logic [3:0] flags_out
);
    // R5: done lasts a single clock
    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: subtract cleared, half-carry set whenever flags are written
    p_fixed_nh_r3: assert property (@(posedge clk) disable iff (rst)
        flags_we |-> (flags_out[2] == 1'b0 && flags_out[1] == 1'b1));

    // R6: memory read lasts a single clock and only inside an operation
    p_mem_single_r6: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (busy && !done) ##1 !mem_rd);

    // R8: illegal completion never writes flags
    p_illegal_nowe_r8: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (done && !flags_we));

    // R9: flag write only in the done clock
    p_we_in_done_r9: assert property (@(posedge clk) disable iff (rst)
        flags_we |-> done);

    // R7: an operation is not cut short or restarted while running
    p_hold_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R7: busy only rises from a start seen while idle
    p_rise_from_start_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
endmodule

bind bittest_unit bittest_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_rd    (mem_rd),
    .flags_we  (flags_we),
    .illegal   (illegal),
    .flags_out (flags_out)
);

// File: tb/bittest_unit_tb.sv
`timescale 1ns/1ps
module bittest_unit_tb;
    localparam int C = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [3:0]  flags_in = 4'h0;
    logic [2:0]  rd_sel;
    logic [7:0]  rd_data;
    logic [7:0]  hl_h, hl_l;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata = 8'h00;
    logic [3:0]  flags_out;
    logic        flags_we, illegal, busy, done;

    logic [7:0]  regs [8];
    logic [7:0]  mem_key = 8'h5A;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bittest_unit #(.CLKS_PER_MC(C)) u_dut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .flags_in(flags_in), .rd_sel(rd_sel), .rd_data(rd_data),
        .hl_h(hl_h), .hl_l(hl_l), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .flags_out(flags_out), .flags_we(flags_we),
        .illegal(illegal), .busy(busy), .done(done)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a, input logic [7:0] k);
        return a[15:8] ^ {a[3:0], a[7:4]} ^ k;
    endfunction

    assign rd_data = regs[rd_sel];
    assign hl_h    = regs[4];
    assign hl_l    = regs[5];

    always_ff @(posedge clk)
        mem_rdata <= mem_rd ? mem_byte(mem_addr, mem_key) : 8'h00;

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input logic [7:0] op, input logic [3:0] fin, input bit hold);
        logic       legal;
        logic [2:0] idx, src;
        logic [7:0] data;
        logic [3:0] exp_f;
        int         exp_len, clk_idx, mem_cnt, mem_at;
        logic [15:0] addr_seen;
        logic [3:0] f_seen;
        logic       we_seen, ill_seen;
        logic [2:0] sel_seen;
        bit         got;
        legal   = (op[7:6] == 2'b01);
        idx     = op[5:3];
        src     = op[2:0];
        data    = (src == 3'd6) ? mem_byte({regs[4], regs[5]}, mem_key) : regs[src];
        exp_len = (!legal) ? 2 * C : (src == 3'd6) ? 3 * C : 2 * C;
        exp_f   = legal ? {~data[idx], 1'b0, 1'b1, fin[0]} : fin;

        @(negedge clk);
        opcode = op; flags_in = fin; start = 1'b1;
        @(posedge clk);
        clk_idx = 2; got = 0; mem_cnt = 0; mem_at = 0; addr_seen = 0;
        f_seen = 0; we_seen = 0; ill_seen = 0; sel_seen = 0;
        while (!got && clk_idx < 40) begin
            @(negedge clk);
            if (hold) begin
                opcode = op ^ 8'hBF; flags_in = ~fin;
            end else begin
                start = 1'b0;
            end
            if (mem_rd) begin mem_cnt++; mem_at = clk_idx; addr_seen = mem_addr; end
            if (done) begin
                got = 1; f_seen = flags_out; we_seen = flags_we;
                ill_seen = illegal; sel_seen = rd_sel;
            end else begin
                @(posedge clk);
                clk_idx++;
            end
        end
        start = 1'b0; flags_in = fin;
        chk(got && clk_idx == exp_len, legal && src == 3'd6 ? "R6" : "R5",
            "done clock index", clk_idx, exp_len);
        if (legal) begin
            chk(f_seen[3] == exp_f[3], "R2", "zero flag", f_seen[3], exp_f[3]);
            chk(f_seen[2:1] == 2'b01, "R3", "N/H flags", f_seen[2:1], 2'b01);
            chk(f_seen[0] == fin[0], "R4", "carry passthrough", f_seen[0], fin[0]);
            chk(we_seen && !ill_seen, "R9", "flags_we/illegal", {we_seen, ill_seen}, 2'b10);
            if (src == 3'd6) begin
                chk(mem_cnt == 1 && mem_at == 2 * C + 1, "R6", "mem_rd clock",
                    mem_at, 2 * C + 1);
                chk(addr_seen == {regs[4], regs[5]}, "R6", "mem_addr",
                    addr_seen, {regs[4], regs[5]});
            end else begin
                chk(mem_cnt == 0, "R9", "no mem read for register", mem_cnt, 0);
                chk(sel_seen == src, "R1", "rd_sel", sel_seen, src);
            end
        end else begin
            chk(ill_seen && !we_seen, "R8", "illegal flag/no write", {ill_seen, we_seen}, 2'b10);
            chk(f_seen == fin, "R8", "flags unchanged", f_seen, fin);
            chk(mem_cnt == 0, "R8", "no mem read", mem_cnt, 0);
        end
        if (hold)
            chk(f_seen == exp_f, "R7", "result with start held", f_seen, exp_f);
        @(posedge clk);
        @(negedge clk);
        chk(!done && !busy, "R5", "single done pulse then idle", {done, busy}, 0);
    endtask

    task automatic fill_regs();
        for (int i = 0; i < 8; i++) regs[i] = 8'($urandom);
        mem_key = 8'($urandom);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1B17_0042));
        fill_regs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !flags_we && !illegal && !mem_rd, "R10", "reset outputs",
            {busy, done, flags_we, illegal, mem_rd}, 0);
        rst = 1'b0;

        // R1 R2 sweep of every bit index and operand code
        for (int b = 0; b < 8; b++) begin
            for (int s = 0; s < 8; s++) begin
                fill_regs();
                run_case({2'b01, 3'(b), 3'(s)}, {3'($urandom), 1'($urandom)}, 1'b0);
            end
        end

        // R2 all-zero and all-ones data
        for (int i = 0; i < 8; i++) regs[i] = 8'h00;
        run_case(8'h7F, 4'h0, 1'b0);
        run_case(8'h40, 4'h1, 1'b0);
        for (int i = 0; i < 8; i++) regs[i] = 8'hFF;
        run_case(8'h7F, 4'h1, 1'b0);
        run_case(8'h57, 4'h0, 1'b0);

        // R7 start and inputs changed while busy
        fill_regs();
        run_case(8'h6A, 4'h9, 1'b1);
        run_case(8'h4E, 4'h6, 1'b1);
        run_case(8'h5B, 4'h2, 1'b1);

        // R8 illegal prefixes
        run_case(8'h06, 4'hA, 1'b0);
        run_case(8'h8E, 4'h5, 1'b0);
        run_case(8'hC3, 4'hF, 1'b0);

        // R4 carry both ways
        fill_regs();
        run_case(8'h6C, 4'h1, 1'b0);
        run_case(8'h6C, 4'h0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule